// File: doc/BRIEF.md
# Sensor Code to Junction Temperature Converter

This block turns a stream of raw thermal-sensor conversion codes into a junction temperature in millidegrees Celsius. A one-cycle start pulse arms it. It then takes a fixed number of strobed samples and averages them. The average goes through a curvature correction and a two-point linear calibration, and the result is rounded up to a fixed step. The block then raises a one-cycle done pulse, and the new temperature appears on a signed output that holds its value until the next result.

Two calibration words come from trim inputs, each with a valid flag in its top bit. When a flag is clear, the block uses a built-in default for that word. Both divisions share one multi-cycle restoring divider, so the arithmetic uses little area and the latency is fixed.

Top module: `tcode_linearizer`

## Requirements
- R1: After an accepted start, the block collects exactly 8 samples, counting only cycles with `samp_valid_i` high. Cycles without the strobe add nothing. The average code is the sum of the 8 codes divided by 8, with the remainder discarded.
- R2: Only bits 11:0 of `samp_code_i` are used. Bits 15:12 have no effect on the result.
- R3: The corrected code is avg*1000000 / (1000000 + avg*13), using integer division.
- R4: The unrounded temperature is (corrected - cal1) * (165000 / (cal0 - cal1)) - 40000 millidegrees. The inner quotient is an integer division.
- R5: The reported temperature is the smallest multiple of 500 that is greater than or equal to the unrounded value. For negative values this moves toward zero.
- R6: cal0 is trim0 bits 11:0 when trim0 bit 31 is 1, and 3148 otherwise. cal1 is trim1 bits 11:0 when trim1 bit 31 is 1, and 503 otherwise. Both trims are captured in the cycle the start pulse is accepted.
- R7: `done_o` is high for exactly one cycle, 84 clock edges after the edge that accepts the 8th sample. `temp_o` changes only together with `done_o`.
- R8: A start pulse that arrives while a conversion is in progress is ignored. The running result and its captured trims are not disturbed.
- R9: Samples strobed while the block is idle are ignored and do not count toward the 8.
- R10: After reset, `done_o` is 0 and `temp_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a conversion |
| samp_valid_i | input | 1 | Sample strobe |
| samp_code_i | input | 16 | Raw sensor code; bits 11:0 are used |
| trim0_i | input | 32 | Upper calibration trim: bit 31 valid, bits 11:0 value |
| trim1_i | input | 32 | Lower calibration trim: bit 31 valid, bits 11:0 value |
| temp_o | output | 32 | Signed junction temperature in millidegrees Celsius |
| done_o | output | 1 | One-cycle pulse marking a new `temp_o` |

## Verification
The result is due a fixed number of cycles after the last sample: one cycle to launch the first division, 40 divider iterations, one cycle to capture the quotient and launch the second division, 40 more iterations, one capture cycle and one output cycle, for 84 edges in total. Each scenario task starts counting at the negative edge that follows the edge accepting the 8th sample. It expects `done_o` exactly at count 84, compares `temp_o` there with a value computed by its own integer model, and confirms on the next negative edge that the pulse has dropped. Start pulses during a busy conversion are injected at set points, once while samples are being collected and once during the divider phase. The result is still checked at the same count.

// File: rtl/tlin_pkg.sv
package tlin_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_DCORR,
    ST_DSLOPE,
    ST_FIN
  } tlin_state_e;

  // Two-point calibration line; all operands already widened to int
  function automatic int lin_temp(int corr, int cal1, int slope, int ofs);
    return (corr - cal1) * slope - ofs;
  endfunction

  // Smallest multiple of g that is >= v (toward zero for negatives)
  function automatic int ceil_gran(int v, int g);
    int r;
    r = v % g;
    return (r > 0) ? (v - r + g) : (v - r);
  endfunction

endpackage

// File: rtl/tlin_accum.sv
module tlin_accum #(
  parameter int CODE_W = 12,
  parameter int N_SAMP = 8,
  localparam int SH    = $clog2(N_SAMP),
  localparam int SUM_W = CODE_W + SH,
  localparam int CNT_W = $clog2(N_SAMP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              take_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CODE_W-1:0] avg_o
);

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o = (cnt_q == CNT_W'(N_SAMP));
  assign take_o = en_i & valid_i & ~full_o;
  assign cnt_o  = cnt_q;
  assign avg_o  = CODE_W'(sum_q >> SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (take_o) begin
      sum_q <= sum_q + SUM_W'(code_i);
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tlin_div.sv
module tlin_div #(
  parameter int W = 40,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         done_o
);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh, rem_sub;
  logic          fits;

  // One restoring step: shift in the next dividend bit, try a subtract
  always_comb begin
    rem_sh  = {rem_q, quo_q[W-1]};
    rem_sub = rem_sh - {1'b0, dvs_q};
    fits    = ~rem_sub[W];
  end

  assign quo_o = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (go_i) begin
      rem_q  <= '0;
      quo_q  <= dvd_i;
      dvs_q  <= dvs_i;
      cnt_q  <= CW'(W);
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fits ? rem_sub[W-1:0] : rem_sh[W-1:0];
      quo_q  <= {quo_q[W-2:0], fits};
      cnt_q  <= cnt_q - CW'(1);
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tcode_linearizer.sv
module tcode_linearizer
  import tlin_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int SAMP_W     = 16,
  parameter int TRIM_W     = 32,
  parameter int N_SAMP     = 8,
  parameter int DIV_W      = 40,
  parameter int CAL0_DEF   = 3148,
  parameter int CAL1_DEF   = 503,
  parameter int CURV_SCALE = 1000000,
  parameter int CURV_K     = 13,
  parameter int SPAN_MC    = 165000,
  parameter int OFS_MC     = 40000,
  parameter int GRAN_MC    = 500,
  localparam int SLOPE_W   = $clog2(SPAN_MC + 1),
  localparam int ACC_CNT_W = $clog2(N_SAMP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                samp_valid_i,
  input  logic [SAMP_W-1:0]   samp_code_i,
  input  logic [TRIM_W-1:0]   trim0_i,
  input  logic [TRIM_W-1:0]   trim1_i,
  output logic signed [31:0]  temp_o,
  output logic                done_o
);

  tlin_state_e          st_q;
  logic [CODE_W-1:0]    cal0_q, cal1_q, corr_q, avg_w;
  logic [SLOPE_W-1:0]   slope_q;
  logic [DIV_W-1:0]     div_dvd, div_dvs, div_quo;
  logic                 div_go, div_done_w;
  logic                 acc_full, acc_take_w, acc_clr;
  logic [ACC_CNT_W-1:0] acc_cnt_w;
  logic                 busy_w, fin_w;
  logic                 unused_samp, unused_bits;

  assign busy_w  = (st_q != ST_IDLE);
  assign fin_w   = (st_q == ST_FIN);
  assign acc_clr = (st_q == ST_IDLE) && start_i;

  generate
    if (SAMP_W > CODE_W) begin : g_samp_hi
      assign unused_samp = ^samp_code_i[SAMP_W-1:CODE_W];
    end else begin : g_samp_eq
      assign unused_samp = 1'b0;
    end
  endgenerate
  assign unused_bits = ^{unused_samp, trim0_i[TRIM_W-2:CODE_W],
                         trim1_i[TRIM_W-2:CODE_W], div_quo[DIV_W-1:SLOPE_W]};

  tlin_accum #(.CODE_W(CODE_W), .N_SAMP(N_SAMP)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (acc_clr),
    .en_i    (st_q == ST_ACC),
    .valid_i (samp_valid_i),
    .code_i  (samp_code_i[CODE_W-1:0]),
    .take_o  (acc_take_w),
    .full_o  (acc_full),
    .cnt_o   (acc_cnt_w),
    .avg_o   (avg_w)
  );

  // One divider, two uses: curvature correction, then calibration slope
  always_comb begin
    div_go = ((st_q == ST_ACC) && acc_full) || ((st_q == ST_DCORR) && div_done_w);
    if (st_q == ST_ACC) begin
      div_dvd = DIV_W'(avg_w) * DIV_W'(CURV_SCALE);
      div_dvs = DIV_W'(CURV_SCALE) + DIV_W'(avg_w) * DIV_W'(CURV_K);
    end else begin
      div_dvd = DIV_W'(SPAN_MC);
      div_dvs = DIV_W'(cal0_q) - DIV_W'(cal1_q);
    end
  end

  tlin_div #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go),
    .dvd_i  (div_dvd),
    .dvs_i  (div_dvs),
    .quo_o  (div_quo),
    .done_o (div_done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cal0_q  <= '0;
      cal1_q  <= '0;
      corr_q  <= '0;
      slope_q <= '0;
      temp_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          cal0_q <= trim0_i[TRIM_W-1] ? trim0_i[CODE_W-1:0] : CODE_W'(CAL0_DEF);
          cal1_q <= trim1_i[TRIM_W-1] ? trim1_i[CODE_W-1:0] : CODE_W'(CAL1_DEF);
          st_q   <= ST_ACC;
        end
        ST_ACC: if (acc_full) st_q <= ST_DCORR;
        ST_DCORR: if (div_done_w) begin
          corr_q <= div_quo[CODE_W-1:0];
          st_q   <= ST_DSLOPE;
        end
        ST_DSLOPE: if (div_done_w) begin
          slope_q <= div_quo[SLOPE_W-1:0];
          st_q    <= ST_FIN;
        end
        ST_FIN: begin
          temp_o <= ceil_gran(lin_temp(int'(corr_q), int'(cal1_q), int'(slope_q), OFS_MC),
                              GRAN_MC);
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlin_chk.sv
module tlin_chk #(
  parameter int N_SAMP  = 8,
  parameter int GRAN_MC = 500,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               done_o,
  input logic signed [31:0] temp_o,
  input logic               busy_w,
  input logic               fin_w,
  input logic               acc_take_w,
  input logic [CNT_W-1:0]   acc_cnt_w,
  input logic               div_done_w
);

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt_w <= CNT_W'(N_SAMP)); // R1

  AST_GRAN_MULT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((temp_o % GRAN_MC) == 0)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(temp_o)); // R7

  AST_DONE_AFTER_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(div_done_w, 2)); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_w && !fin_w) |=> busy_w); // R8

  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !acc_take_w); // R9

endmodule

bind tcode_linearizer tlin_chk #(.N_SAMP(N_SAMP), .GRAN_MC(GRAN_MC), .CNT_W(ACC_CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .done_o     (done_o),
  .temp_o     (temp_o),
  .busy_w     (busy_w),
  .fin_w      (fin_w),
  .acc_take_w (acc_take_w),
  .acc_cnt_w  (acc_cnt_w),
  .div_done_w (div_done_w)
);

// File: tb/tb_tcode_linearizer.sv
module tb_tcode_linearizer;

  localparam int LAT = 2 * 40 + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        samp_valid_i = 1'b0;
  logic [15:0] samp_code_i = '0;
  logic [31:0] trim0_i = '0;
  logic [31:0] trim1_i = '0;
  logic signed [31:0] temp_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tcode_linearizer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .samp_valid_i (samp_valid_i),
    .samp_code_i  (samp_code_i),
    .trim0_i      (trim0_i),
    .trim1_i      (trim1_i),
    .temp_o       (temp_o),
    .done_o       (done_o)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent integer model of the conversion
  function automatic longint model(int s[8], logic [31:0] t0, logic [31:0] t1);
    longint c0, c1, tot, av, cr, sl, v;
    c0 = t0[31] ? longint'(t0 & 32'hFFF) : 3148;
    c1 = t1[31] ? longint'(t1 & 32'hFFF) : 503;
    tot = 0;
    foreach (s[i]) tot += longint'(s[i] & 'hFFF);
    av = tot / 8;
    cr = (av * 1000000) / (1000000 + 13 * av);
    sl = 165000 / (c0 - c1);
    v  = (cr - c1) * sl - 40000;
    if (v >= 0) return ((v + 499) / 500) * 500;
    return -(((-v) / 500) * 500);
  endfunction

  // Generic conversion run with optional gaps, idle noise and start pokes
  task automatic run(string req, int s[8], logic [31:0] t0, logic [31:0] t1,
                     bit gaps, bit poke, int idle_pre);
    longint exp_t;
    int c;
    exp_t = model(s, t0, t1);
    trim0_i = t0;
    trim1_i = t1;
    for (int k = 0; k < idle_pre; k++) begin
      samp_valid_i = 1'b1; samp_code_i = 16'h0FFF;
      @(negedge clk);
    end
    samp_valid_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (gaps && (i % 2 == 1)) begin
        samp_valid_i = 1'b0; samp_code_i = 16'hFFFF;
        @(negedge clk);
      end
      samp_valid_i = 1'b1;
      samp_code_i  = s[i][15:0];
      start_i = poke && (i == 3);
      @(negedge clk);
      start_i = 1'b0;
    end
    samp_valid_i = 1'b0;
    c = 0;
    while (c < 200) begin
      @(negedge clk);
      c++;
      if (poke && c == 20) begin
        start_i = 1'b1; trim0_i = 32'h8000_0900; trim1_i = 32'h8000_0100;
      end
      if (c == 21) start_i = 1'b0;
      if (done_o) break;
    end
    chk(c == LAT, {req, " R7 latency"}, c, LAT);
    chk(temp_o == exp_t, req, temp_o, exp_t);
    @(negedge clk);
    chk(done_o == 1'b0, {req, " R7 pulse width"}, done_o, 0);
    trim0_i = '0; trim1_i = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0, "R10 done after reset", done_o, 0);
    chk(temp_o == 0, "R10 temp after reset", temp_o, 0);
  endtask

  task automatic t_defaults();
    int s[8] = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000};
    run("R3 R4 R6 default trims", s, 32'h0, 32'h0, 0, 0, 0);
    chk(temp_o == -9500, "R5 negative rounds toward zero", temp_o, -9500);
  endtask

  task automatic t_fuse();
    int s[8] = '{2900, 3050, 3111, 3333, 3401, 3499, 3555, 3600};
    run("R1 R6 fuse trims truncating average", s, 32'h8000_0C50, 32'h8000_01F0, 0, 0, 0);
  endtask

  task automatic t_flag_clear();
    int s[8] = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    run("R6 flag clear uses defaults", s, 32'h0000_0123, 32'h0000_0456, 0, 0, 0);
  endtask

  task automatic t_upper_bits();
    int s[8] = '{'hA3E8, 'hF3E8, 'h13E8, 'h83E8, 'h53E8, 'hC3E8, 'h73E8, 'h23E8};
    run("R2 upper sample bits ignored", s, 32'h0, 32'h0, 0, 0, 0);
    chk(temp_o == -9500, "R2 same as clean code 1000", temp_o, -9500);
  endtask

  task automatic t_gaps_idle();
    int s[8] = '{100, 4095, 1500, 2500, 700, 3900, 1234, 2222};
    run("R1 R9 strobe gaps and idle samples", s, 32'h8000_0C4C, 32'h8000_01F7, 1, 0, 3);
  endtask

  task automatic t_poke();
    int s[8] = '{1800, 1810, 1820, 1830, 1840, 1850, 1860, 1870};
    run("R8 start while busy ignored", s, 32'h8000_0C40, 32'h8000_0200, 0, 1, 0);
  endtask

  task automatic t_high();
    int s[8] = '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095};
    run("R4 R5 full scale positive", s, 32'h8000_0C4C, 32'h8000_01F7, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_fuse();
    t_flag_clear();
    t_upper_bits();
    t_gaps_idle();
    t_poke();
    t_high();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule